// File: doc/BRIEF.md
# Parallel RGB Panel Scan Timer

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, data-enable, a pixel-rate clock enable and a pixel clock wave. Software loads the porch, sync and active sizes for both axes, each as its count minus one, along with a divider and four polarity bits. The block then walks the raster. A line runs sync pulse first, then back porch, then active pixels, then front porch. A frame follows the same order, counted in lines.

The scan-out logic takes its pixel coordinates from `pix_x` / `pix_y` while data-enable is active. All raster state moves only on `pclk_en`, so the block runs in the source clock domain. The master enable `video_en` is sampled only at a frame boundary. A frame therefore never starts or stops partway through. Each time a frame starts, which is also when vsync asserts, a sticky status bit is set. That bit drives an interrupt line through an enable and is cleared by writing one to it.

Top module: `pscan_timing`

## Requirements
- R1: Each timing field holds its count minus one. A line lasts (h_sync_m1+1)+(h_back_m1+1)+(h_act_m1+1)+(h_front_m1+1) pixel ticks. A frame lasts the same sum of the vertical fields, counted in lines.
- R2: Within a line, the raw hsync is active during the first h_sync_m1+1 ticks. Within a frame, the raw vsync is active during the first v_sync_m1+1 lines. The order of regions is sync, back porch, active, front porch.
- R3: Raw data-enable is active only when both the horizontal and vertical positions are inside their active regions.
- R4: While data-enable is active, `pix_x` / `pix_y` give the position relative to the first active pixel and line, starting at 0. At all other times both read 0.
- R5: When an inversion bit (`inv_hsync`, `inv_vsync`, `inv_de`, `inv_pclk`) is 1, the matching output is the complement of its raw level. When the bit is 0, the output carries the raw level, where active is 1.
- R6: A divider phase counter starts at 0 after reset and counts 0..clk_div_m1. `pclk_en` is high in the cycle where the counter holds clk_div_m1. This gives one tick every clk_div_m1+1 source cycles. A value of 0 bypasses the divider, so `pclk_en` is high on every cycle.
- R7: Before inversion, `pclk_out` is high while the phase counter is at or below clk_div_m1/2 (rounded down). In bypass mode it is therefore constantly high, and the source clock itself serves as the pixel clock.
- R8: `video_en` is sampled only at a boundary. A boundary is a tick while stopped, or the tick on the last pixel of the last line. While stopped, sync, data-enable and coordinates are all inactive. The first raster cycle after a start is at position (0,0).
- R9: Each frame start sets `irq_status` in the same cycle that vsync asserts. `irq` equals irq_status AND irq_en.
- R10: A high `irq_clr` clears `irq_status` on the next edge. If a frame start and a clear fall in the same cycle, the set wins.
- R11: Reset makes every output inactive at raw polarity, sets the coordinates to 0, clears irq_status and stops the raster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| video_en | input | 1 | Master enable, sampled at frame boundaries |
| h_sync_m1 | input | CNT_W | Horizontal sync width minus one |
| h_back_m1 | input | CNT_W | Horizontal back porch minus one |
| h_act_m1 | input | CNT_W | Active pixels per line minus one |
| h_front_m1 | input | CNT_W | Horizontal front porch minus one |
| v_sync_m1 | input | CNT_W | Vertical sync width in lines minus one |
| v_back_m1 | input | CNT_W | Vertical back porch minus one |
| v_act_m1 | input | CNT_W | Active lines minus one |
| v_front_m1 | input | CNT_W | Vertical front porch minus one |
| clk_div_m1 | input | DIV_W | Pixel divide minus one, 0 bypasses |
| inv_hsync | input | 1 | Invert hsync |
| inv_vsync | input | 1 | Invert vsync |
| inv_de | input | 1 | Invert data-enable |
| inv_pclk | input | 1 | Invert pixel clock wave |
| irq_en | input | 1 | Frame interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear for irq_status |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data-enable |
| pclk_en | output | 1 | Pixel tick enable |
| pclk_out | output | 1 | Divided pixel clock wave |
| pix_x | output | CNT_W | Active pixel column |
| pix_y | output | CNT_W | Active line number |
| irq_status | output | 1 | Sticky frame-start status |
| irq | output | 1 | Frame interrupt line |

## Verification
The bench builds the block with CNT_W = 6 and the default DIV_W = 8. This keeps the timing fields small, so a whole frame lasts only a few dozen pixel ticks. Many frame wraps, stop/start boundaries and interrupt sets and clears therefore fit in a short run. The 8-bit divider is driven at bypass, at a divide of 3 and at its full-scale value of 255 (a divide of 256), which exercises the largest phase period. Two raster geometries are used with all four polarity bits flipped.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

  // Region of one raster axis, in scan order.
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;

  // Bit positions of the polarity-controlled outputs.
  localparam int unsigned OUT_HS   = 0;
  localparam int unsigned OUT_VS   = 1;
  localparam int unsigned OUT_DE   = 2;
  localparam int unsigned OUT_PCLK = 3;
  localparam int unsigned OUT_N    = 4;

endpackage

// File: rtl/pscan_pclk_div.sv
module pscan_pclk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick,
  output logic             phase
);

  logic [DIV_W-1:0] cnt_q;

  // Terminal count reached: one tick per div_m1+1 cycles, every cycle at 0.
  function automatic logic at_term(input logic [DIV_W-1:0] c,
                                   input logic [DIV_W-1:0] m1);
    return c >= m1;
  endfunction

  // First half of the period (rounded down) drives the wave high.
  function automatic logic first_half(input logic [DIV_W-1:0] c,
                                      input logic [DIV_W-1:0] m1);
    return c <= (m1 >> 1);
  endfunction

  assign tick  = at_term(cnt_q, div_m1);
  assign phase = first_half(cnt_q, div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + DIV_W'(1);
  end

endmodule

// File: rtl/pscan_axis.sv
module pscan_axis
  import pscan_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  localparam int unsigned SUM_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] sync_m1,
  input  logic [CNT_W-1:0] back_m1,
  input  logic [CNT_W-1:0] act_m1,
  input  logic [CNT_W-1:0] front_m1,
  output logic [SUM_W-1:0] pos,
  output logic             at_last,
  output seg_e             seg,
  output logic [CNT_W-1:0] rel
);

  function automatic logic [SUM_W-1:0] seg_len(input logic [CNT_W-1:0] m1);
    return SUM_W'(m1) + SUM_W'(1);
  endfunction

  logic [SUM_W-1:0] sync_end, act_start, act_end, last_pos;
  logic [SUM_W-1:0] pos_q;

  assign sync_end  = seg_len(sync_m1);
  assign act_start = sync_end + seg_len(back_m1);
  assign act_end   = act_start + seg_len(act_m1);
  assign last_pos  = act_end + SUM_W'(front_m1);

  assign pos     = pos_q;
  assign at_last = pos_q >= last_pos;
  assign rel     = CNT_W'(pos_q - act_start);

  always_comb begin
    if (pos_q < sync_end)       seg = SEG_SYNC;
    else if (pos_q < act_start) seg = SEG_BACK;
    else if (pos_q < act_end)   seg = SEG_ACT;
    else                        seg = SEG_FRONT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos_q <= '0;
    else if (clear)   pos_q <= '0;
    else if (step)    pos_q <= at_last ? '0 : pos_q + SUM_W'(1);
  end

endmodule

// File: rtl/pscan_frame_irq.sv
module pscan_frame_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic clr,
  input  logic en,
  output logic status,
  output logic irq
);

  logic status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           status_q <= 1'b0;
    else if (frame_start) status_q <= 1'b1;
    else if (clr)         status_q <= 1'b0;
  end

  assign status = status_q;
  assign irq    = status_q & en;

endmodule

// File: rtl/pscan_timing.sv
module pscan_timing
  import pscan_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             video_en,
  input  logic [CNT_W-1:0] h_sync_m1,
  input  logic [CNT_W-1:0] h_back_m1,
  input  logic [CNT_W-1:0] h_act_m1,
  input  logic [CNT_W-1:0] h_front_m1,
  input  logic [CNT_W-1:0] v_sync_m1,
  input  logic [CNT_W-1:0] v_back_m1,
  input  logic [CNT_W-1:0] v_act_m1,
  input  logic [CNT_W-1:0] v_front_m1,
  input  logic [DIV_W-1:0] clk_div_m1,
  input  logic             inv_hsync,
  input  logic             inv_vsync,
  input  logic             inv_de,
  input  logic             inv_pclk,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             pclk_en,
  output logic             pclk_out,
  output logic [CNT_W-1:0] pix_x,
  output logic [CNT_W-1:0] pix_y,
  output logic             irq_status,
  output logic             irq
);

  localparam int unsigned SUM_W = CNT_W + 2;

  // Named internal events, visible to the bound checker.
  logic             tick;
  logic             pclk_phase;
  logic             run_q;
  logic             boundary;
  logic             frame_start;
  logic             h_last, v_last;
  logic [SUM_W-1:0] h_pos, v_pos;
  seg_e             h_seg, v_seg;
  logic [CNT_W-1:0] h_rel, v_rel;
  logic             hs_raw, vs_raw, de_raw;

  pscan_pclk_div #(.DIV_W(DIV_W)) div_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_m1 (clk_div_m1),
    .tick   (tick),
    .phase  (pclk_phase)
  );

  // A boundary is any tick while stopped, or the final tick of a frame.
  assign boundary    = tick && (!run_q || (h_last && v_last));
  assign frame_start = boundary && video_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= 1'b0;
    else if (boundary) run_q <= video_en;
  end

  pscan_axis #(.CNT_W(CNT_W)) h_axis_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (boundary),
    .step     (tick && run_q),
    .sync_m1  (h_sync_m1),
    .back_m1  (h_back_m1),
    .act_m1   (h_act_m1),
    .front_m1 (h_front_m1),
    .pos      (h_pos),
    .at_last  (h_last),
    .seg      (h_seg),
    .rel      (h_rel)
  );

  pscan_axis #(.CNT_W(CNT_W)) v_axis_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (boundary),
    .step     (tick && run_q && h_last),
    .sync_m1  (v_sync_m1),
    .back_m1  (v_back_m1),
    .act_m1   (v_act_m1),
    .front_m1 (v_front_m1),
    .pos      (v_pos),
    .at_last  (v_last),
    .seg      (v_seg),
    .rel      (v_rel)
  );

  assign hs_raw = run_q && (h_seg == SEG_SYNC);
  assign vs_raw = run_q && (v_seg == SEG_SYNC);
  assign de_raw = run_q && (h_seg == SEG_ACT) && (v_seg == SEG_ACT);

  assign pix_x = de_raw ? h_rel : '0;
  assign pix_y = de_raw ? v_rel : '0;

  // Polarity stage, one XOR per controlled output.
  logic [OUT_N-1:0] raw_vec, inv_vec, out_vec;

  assign raw_vec[OUT_HS]   = hs_raw;
  assign raw_vec[OUT_VS]   = vs_raw;
  assign raw_vec[OUT_DE]   = de_raw;
  assign raw_vec[OUT_PCLK] = pclk_phase;
  assign inv_vec[OUT_HS]   = inv_hsync;
  assign inv_vec[OUT_VS]   = inv_vsync;
  assign inv_vec[OUT_DE]   = inv_de;
  assign inv_vec[OUT_PCLK] = inv_pclk;

  for (genvar gi = 0; gi < OUT_N; gi++) begin : g_pol
    assign out_vec[gi] = raw_vec[gi] ^ inv_vec[gi];
  end

  assign hsync    = out_vec[OUT_HS];
  assign vsync    = out_vec[OUT_VS];
  assign de       = out_vec[OUT_DE];
  assign pclk_out = out_vec[OUT_PCLK];
  assign pclk_en  = tick;

  pscan_frame_irq irq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .clr         (irq_clr),
    .en          (irq_en),
    .status      (irq_status),
    .irq         (irq)
  );

endmodule

// File: rtl/pscan_timing_chk.sv
module pscan_timing_chk #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DIV_W = 8,
  localparam int unsigned SUM_W = CNT_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [DIV_W-1:0] div_m1,
  input logic             boundary,
  input logic             frame_start,
  input logic             run_q,
  input logic             hs_raw,
  input logic             vs_raw,
  input logic             de_raw,
  input logic [CNT_W-1:0] pix_x,
  input logic [SUM_W-1:0] h_pos,
  input logic             irq_status
);

  // R3
  de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> (!hs_raw && !vs_raw));

  // R4
  first_pixel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_raw) |-> (pix_x == '0));

  // R6
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_m1 != '0) |=> (!tick || div_m1 != $past(div_m1)));

  // R1
  hpos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (h_pos == $past(h_pos)));

  // R8
  run_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q != $past(run_q)) |-> $past(boundary));

  // R9
  status_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status) |-> $past(frame_start));

  // R9
  start_syncs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (hs_raw && vs_raw));

endmodule

bind pscan_timing pscan_timing_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .div_m1      (clk_div_m1),
  .boundary    (boundary),
  .frame_start (frame_start),
  .run_q       (run_q),
  .hs_raw      (hs_raw),
  .vs_raw      (vs_raw),
  .de_raw      (de_raw),
  .pix_x       (pix_x),
  .h_pos       (h_pos),
  .irq_status  (irq_status)
);

// File: tb/pscan_timing_tb_top.sv
`timescale 1ns/1ps
module pscan_timing_tb_top;

  localparam int CW = 6;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic video_en = 1'b0;
  logic [CW-1:0] h_sync_m1 = '0, h_back_m1 = '0, h_act_m1 = '0, h_front_m1 = '0;
  logic [CW-1:0] v_sync_m1 = '0, v_back_m1 = '0, v_act_m1 = '0, v_front_m1 = '0;
  logic [DW-1:0] clk_div_m1 = '0;
  logic inv_hsync = 1'b0, inv_vsync = 1'b0, inv_de = 1'b0, inv_pclk = 1'b0;
  logic irq_en = 1'b0, irq_clr = 1'b0;
  logic hsync, vsync, de, pclk_en, pclk_out, irq_status, irq;
  logic [CW-1:0] pix_x, pix_y;

  always #5 clk = ~clk;

  pscan_timing #(.CNT_W(CW), .DIV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .video_en(video_en),
    .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1), .h_act_m1(h_act_m1), .h_front_m1(h_front_m1),
    .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1), .v_act_m1(v_act_m1), .v_front_m1(v_front_m1),
    .clk_div_m1(clk_div_m1), .inv_hsync(inv_hsync), .inv_vsync(inv_vsync), .inv_de(inv_de),
    .inv_pclk(inv_pclk), .irq_en(irq_en), .irq_clr(irq_clr),
    .hsync(hsync), .vsync(vsync), .de(de), .pclk_en(pclk_en), .pclk_out(pclk_out),
    .pix_x(pix_x), .pix_y(pix_y), .irq_status(irq_status), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference: raster position as plain integers.
  int m_dc = 0, m_run = 0, m_h = 0, m_v = 0, m_st = 0;
  int htot, vtot, tk, bnd;

  function automatic int hlen();
    return h_sync_m1 + h_back_m1 + h_act_m1 + h_front_m1 + 4;
  endfunction
  function automatic int vlen();
    return v_sync_m1 + v_back_m1 + v_act_m1 + v_front_m1 + 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dc = 0; m_run = 0; m_h = 0; m_v = 0; m_st = 0;
    end else begin
      htot = hlen();
      vtot = vlen();
      tk   = (m_dc >= clk_div_m1) ? 1 : 0;
      bnd  = (tk != 0) && ((m_run == 0) || (m_h >= htot - 1 && m_v >= vtot - 1)) ? 1 : 0;
      if (bnd != 0 && video_en) m_st = 1;
      else if (irq_clr)         m_st = 0;
      if (bnd != 0) begin
        m_run = video_en ? 1 : 0; m_h = 0; m_v = 0;
      end else if (tk != 0 && m_run != 0) begin
        if (m_h >= htot - 1) begin m_h = 0; m_v = m_v + 1; end
        else m_h = m_h + 1;
      end
      m_dc = (tk != 0) ? 0 : m_dc + 1;
    end
  end

  // Compare every cycle away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int hs0, hb0, ha0, vs0, vb0, va0, e_hs, e_vs, e_de, e_px, e_py;
      hs0 = h_sync_m1 + 1; hb0 = hs0 + h_back_m1 + 1; ha0 = hb0 + h_act_m1 + 1;
      vs0 = v_sync_m1 + 1; vb0 = vs0 + v_back_m1 + 1; va0 = vb0 + v_act_m1 + 1;
      e_hs = (m_run != 0 && m_h < hs0) ? 1 : 0;
      e_vs = (m_run != 0 && m_v < vs0) ? 1 : 0;
      e_de = (m_run != 0 && m_h >= hb0 && m_h < ha0 && m_v >= vb0 && m_v < va0) ? 1 : 0;
      e_px = (e_de != 0) ? m_h - hb0 : 0;
      e_py = (e_de != 0) ? m_v - vb0 : 0;
      chk("R1/R2/R5/R8 hsync", int'(hsync), e_hs ^ int'(inv_hsync));
      chk("R1/R2/R5/R8 vsync", int'(vsync), e_vs ^ int'(inv_vsync));
      chk("R3/R5 de", int'(de), e_de ^ int'(inv_de));
      chk("R4 pix_x", int'(pix_x), e_px);
      chk("R4 pix_y", int'(pix_y), e_py);
      chk("R6 pclk_en", int'(pclk_en), (m_dc >= clk_div_m1) ? 1 : 0);
      chk("R7/R5 pclk_out", int'(pclk_out), ((m_dc <= (clk_div_m1 / 2)) ? 1 : 0) ^ int'(inv_pclk));
      chk("R9/R10 irq_status", int'(irq_status), m_st);
      chk("R9 irq", int'(irq), m_st & int'(irq_en));
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #1;
    h_sync_m1 = 1; h_back_m1 = 0; h_act_m1 = 3; h_front_m1 = 0;
    v_sync_m1 = 0; v_back_m1 = 0; v_act_m1 = 2; v_front_m1 = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 hsync", int'(hsync), 0);
    chk("R11 vsync", int'(vsync), 0);
    chk("R11 de", int'(de), 0);
    chk("R11 pix_x", int'(pix_x), 0);
    chk("R11 irq_status", int'(irq_status), 0);
    #1 rst_n = 1'b1;
    wait_cyc(6);                           // idle: outputs stay inactive (R8)
    video_en = 1'b1; irq_en = 1'b1;
    for (int i = 0; i < 6; i++) begin      // bypass divider, pulses of clear
      wait_cyc(30);
      irq_clr = 1'b1; wait_cyc(1); irq_clr = 1'b0;
    end
    wait_cyc(20);
    video_en = 1'b0;                       // stop mid-frame, ends at boundary
    wait_cyc(120);
    h_sync_m1 = 0; h_back_m1 = 2; h_act_m1 = 5; h_front_m1 = 1;
    v_sync_m1 = 2; v_back_m1 = 0; v_act_m1 = 1; v_front_m1 = 0;
    clk_div_m1 = 2;
    inv_hsync = 1'b1; inv_vsync = 1'b1; inv_de = 1'b1; inv_pclk = 1'b1;
    video_en = 1'b1;
    irq_clr = 1'b1;                        // held clear: set must still win (R10)
    wait_cyc(400);
    irq_clr = 1'b0; irq_en = 1'b0;
    wait_cyc(300);
    irq_en = 1'b1;
    inv_hsync = 1'b0; inv_vsync = 1'b0; inv_de = 1'b0; inv_pclk = 1'b0;
    clk_div_m1 = 8'd255;                   // full-scale divide
    wait_cyc(25000);
    video_en = 1'b0;
    clk_div_m1 = 1;
    wait_cyc(8000);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule